// File: doc/BRIEF.md
# Thermistor Code to Temperature Converter

This block turns a 10-bit ADC reading into a signed temperature in millidegrees Celsius. A mode input picks one of two conversions. In thermistor mode the code is located in a fixed table of breakpoint codes, and the result is interpolated linearly between the two breakpoints that surround it. In die-sensor mode the code goes through a direct affine formula. Either path can report an error instead of a temperature.

A request is a single-cycle `start` pulse, with `code_in` and `die_mode` valid in that cycle. The block then raises `busy` and later pulses `done` for one cycle. In that cycle `err` and `temp_mc` hold the outcome. The block's state machine has five states:
- IDLE waits for `start`.
- PROBE runs one step of the binary search per cycle.
- PREP forms the interpolation numerator and span, and launches the divider.
- DIVIDE waits for the restoring divider.
- DONE presents the result.

Its transitions are:
- IDLE to DONE, for a die-sensor request.
- IDLE to PROBE, for a thermistor request.
- PROBE to PROBE, which narrows the search range.
- PROBE to DONE, on an exact hit or when the search range is exhausted.
- PROBE to PREP, when the code falls between two breakpoints.
- PREP to DIVIDE.
- PREP to DONE, on a zero span.
- DIVIDE to DONE, when the quotient is ready.
- DONE to IDLE.

Top module: `thermistor_temp_conv`

## Requirements
- R1: The table holds 34 breakpoints whose codes fall strictly from 977 at index 0 to 31 at index 33. The temperature of index i is -20 + 5*i degrees Celsius.
- R2: Thermistor lookup is a binary search over indices lo=0 and hi=33, with mid=(lo+hi)/2. It ends on equality with entry mid. It also ends when mid>0 and the code lies strictly between entry mid and entry mid-1. Otherwise hi becomes mid-1 if the code exceeds entry mid, and lo becomes mid+1 if it does not. If lo passes hi, the result is an error; codes above 977 or below 31 end this way.
- R3: A code equal to a breakpoint gives that breakpoint's temperature times 1000.
- R4: A code between entry i (code x0, temperature y0) and entry i-1 (x1, y1) gives ((x-x0)*y1 + (x1-x)*y0)*1000 / (x1-x0). The product is formed before the divide, and the quotient truncates toward zero.
- R5: In die-sensor mode the result is 382100 - 526*code millidegrees, and `done` rises in the cycle right after the start edge.
- R6: In die-sensor mode, a code below 488 or above 802 reports an error.
- R7: When an error is reported, `err` is 1 and `temp_mc` is 0 while `done` is high. On a valid result `err` is 0.
- R8: `done` lasts exactly one cycle. `busy` is high from the cycle after an accepted start through the `done` cycle, and low otherwise.
- R9: A `start` that arrives while `busy` is high is ignored. The running request completes with its own result, and no additional `done` follows.
- R10: After reset, `busy`, `done` and `err` are 0 and `temp_mc` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Request pulse, accepted only when idle |
| code_in | input | 10 | ADC code to convert |
| die_mode | input | 1 | 1 selects the die-sensor formula, 0 selects the thermistor table |
| busy | output | 1 | A request is in progress |
| done | output | 1 | One-cycle pulse: the result is valid |
| err | output | 1 | The code cannot be converted (valid with done) |
| temp_mc | output | 32 | Signed temperature in millidegrees Celsius (valid with done) |

## Verification
The assertions take three things for granted about the inputs. First, `start` is only meaningful as a pulse. Second, the code and mode are sampled only in the accepting cycle. Third, the divider is never loaded with a zero span, which the strictly falling table guarantees.

The stimulus lowers `start` one cycle after each request. It holds `start` high during busy cycles only to check that such pulses are ignored. It sweeps every code in thermistor mode, including values outside the table, and a stride of codes across and beyond the die-sensor window.

// File: rtl/thermconv_pkg.sv
package thermconv_pkg;

    localparam int BP_COUNT  = 34;
    localparam int BP_T0_C   = -20;
    localparam int BP_STEP_C = 5;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_PROBE,
        ST_PREP,
        ST_DIVIDE,
        ST_DONE
    } conv_state_e;

    // Breakpoint codes, strictly falling with rising temperature.
    function automatic logic [15:0] bp_code(input int unsigned i);
        case (i)
            0:  return 16'd977;
            1:  return 16'd961;
            2:  return 16'd941;
            3:  return 16'd917;
            4:  return 16'd887;
            5:  return 16'd853;
            6:  return 16'd813;
            7:  return 16'd769;
            8:  return 16'd720;
            9:  return 16'd669;
            10: return 16'd615;
            11: return 16'd561;
            12: return 16'd508;
            13: return 16'd456;
            14: return 16'd407;
            15: return 16'd357;
            16: return 16'd315;
            17: return 16'd277;
            18: return 16'd243;
            19: return 16'd212;
            20: return 16'd186;
            21: return 16'd162;
            22: return 16'd140;
            23: return 16'd107;
            24: return 16'd94;
            25: return 16'd82;
            26: return 16'd72;
            27: return 16'd64;
            28: return 16'd56;
            29: return 16'd50;
            30: return 16'd44;
            31: return 16'd39;
            32: return 16'd35;
            33: return 16'd31;
            default: return 16'd0;
        endcase
    endfunction

endpackage

// File: rtl/thermconv_table.sv
module thermconv_table
    import thermconv_pkg::*;
#(
    parameter int AW     = 6,
    parameter int CODE_W = 10,
    parameter int TEMP_W = 16
) (
    input  logic        [AW-1:0]     idx,
    output logic        [CODE_W-1:0] code,
    output logic signed [TEMP_W-1:0] temp_c
);

    // Temperature follows from the index; only the codes are stored.
    always_comb begin
        code   = CODE_W'(bp_code(int'(idx)));
        temp_c = TEMP_W'(BP_T0_C + BP_STEP_C * int'(idx));
    end

endmodule

// File: rtl/thermconv_divider.sv
module thermconv_divider #(
    parameter int W  = 32,
    parameter int DW = 11
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          load,
    input  logic [W-1:0]  dividend,
    input  logic [DW-1:0] divisor,
    output logic          fin,
    output logic [W-1:0]  quotient
);

    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  quo_q;
    logic [DW:0]   rem_q;
    logic [DW-1:0] dvs_q;
    logic [CW-1:0] cnt_q;
    logic          fin_q;

    logic [DW:0]   rem_sh;
    logic [DW:0]   rem_nx;
    logic          fits;

    // One restoring step: shift in the next dividend bit, subtract if it fits.
    always_comb begin
        rem_sh = {rem_q[DW-1:0], quo_q[W-1]};
        fits   = (rem_sh >= {1'b0, dvs_q});
        rem_nx = fits ? (rem_sh - {1'b0, dvs_q}) : rem_sh;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            quo_q <= '0;
            rem_q <= '0;
            dvs_q <= '0;
            cnt_q <= '0;
            fin_q <= 1'b0;
        end else begin
            fin_q <= 1'b0;
            if (load) begin
                quo_q <= dividend;
                rem_q <= '0;
                dvs_q <= divisor;
                cnt_q <= CW'(W);
            end else if (cnt_q != '0) begin
                quo_q <= {quo_q[W-2:0], fits};
                rem_q <= rem_nx;
                cnt_q <= cnt_q - 1'b1;
                if (cnt_q == CW'(1)) begin
                    fin_q <= 1'b1;
                end
            end
        end
    end

    assign fin      = fin_q;
    assign quotient = quo_q;

    // R4: a finished division leaves a remainder below the divisor
    a_r4_rem_below_divisor: assert property (@(posedge clk) disable iff (!rst_n)
        fin_q |-> (rem_q < {1'b0, dvs_q}));

endmodule

// File: rtl/thermistor_temp_conv.sv
module thermistor_temp_conv
    import thermconv_pkg::*;
#(
    parameter int CODE_W    = 10,
    parameter int OUT_W     = 32,
    parameter int DIV_W     = 32,
    parameter int NBP       = BP_COUNT,
    parameter int MILLI     = 1000,
    parameter int DIE_OFS   = 382100,
    parameter int DIE_SLOPE = 526,
    parameter int DIE_MIN   = 488,
    parameter int DIE_MAX   = 802
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [CODE_W-1:0]       code_in,
    input  logic                    die_mode,
    output logic                    busy,
    output logic                    done,
    output logic                    err,
    output logic signed [OUT_W-1:0] temp_mc
);

    localparam int AW     = $clog2(NBP);
    localparam int IW     = AW + 2;
    localparam int TEMP_W = 16;
    localparam int SPAN_W = CODE_W + 1;

    conv_state_e state_q, state_d;

    logic [CODE_W-1:0]       code_q;
    logic                    die_q;
    logic signed [IW-1:0]    lo_q, lo_d, hi_q, hi_d;
    logic [AW-1:0]           hit_q, hit_d;
    logic signed [OUT_W-1:0] res_q, res_d;
    logic                    err_q, err_d;
    logic                    neg_q, neg_d;

    logic signed [IW-1:0]    mid;
    logic [AW-1:0]           cur_addr, prev_addr;
    logic [CODE_W-1:0]       cur_code, prev_code;
    logic signed [TEMP_W-1:0] cur_temp, prev_temp;

    logic                    div_load;
    logic [DIV_W-1:0]        div_num;
    logic [SPAN_W-1:0]       div_den;
    logic                    div_fin;
    logic [DIV_W-1:0]        div_quo;

    int                      span_i;
    int                      nr_i;
    longint                  numer_l;
    longint                  mag_l;
    int                      die_i;
    logic signed [OUT_W-1:0] quo_s;

    assign mid       = (lo_q + hi_q) >>> 1;
    assign cur_addr  = (state_q == ST_PREP) ? hit_q : mid[AW-1:0];
    assign prev_addr = (cur_addr == '0) ? '0 : (cur_addr - 1'b1);

    thermconv_table #(.AW(AW), .CODE_W(CODE_W), .TEMP_W(TEMP_W)) u_cur (
        .idx    (cur_addr),
        .code   (cur_code),
        .temp_c (cur_temp)
    );

    thermconv_table #(.AW(AW), .CODE_W(CODE_W), .TEMP_W(TEMP_W)) u_prev (
        .idx    (prev_addr),
        .code   (prev_code),
        .temp_c (prev_temp)
    );

    thermconv_divider #(.W(DIV_W), .DW(SPAN_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (div_load),
        .dividend (div_num),
        .divisor  (div_den),
        .fin      (div_fin),
        .quotient (div_quo)
    );

    // State register and datapath registers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            code_q  <= '0;
            die_q   <= 1'b0;
            lo_q    <= '0;
            hi_q    <= '0;
            hit_q   <= '0;
            res_q   <= '0;
            err_q   <= 1'b0;
            neg_q   <= 1'b0;
        end else begin
            state_q <= state_d;
            if (state_q == ST_IDLE && start) begin
                code_q <= code_in;
                die_q  <= die_mode;
            end
            lo_q  <= lo_d;
            hi_q  <= hi_d;
            hit_q <= hit_d;
            res_q <= res_d;
            err_q <= err_d;
            neg_q <= neg_d;
        end
    end

    // Arithmetic for the die formula and the interpolation numerator
    always_comb begin
        die_i   = DIE_OFS - DIE_SLOPE * int'(code_in);
        span_i  = int'(prev_code) - int'(cur_code);
        nr_i    = (int'(code_q) - int'(cur_code)) * int'(prev_temp)
                + (int'(prev_code) - int'(code_q)) * int'(cur_temp);
        numer_l = longint'(nr_i) * longint'(MILLI);
        mag_l   = (numer_l < 0) ? -numer_l : numer_l;
        quo_s   = $signed(OUT_W'(div_quo));
    end

    // Next-state and datapath update
    always_comb begin
        state_d  = state_q;
        lo_d     = lo_q;
        hi_d     = hi_q;
        hit_d    = hit_q;
        res_d    = res_q;
        err_d    = err_q;
        neg_d    = neg_q;
        div_load = 1'b0;
        div_num  = DIV_W'(mag_l);
        div_den  = SPAN_W'(span_i);
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    if (die_mode) begin
                        if (int'(code_in) < DIE_MIN || int'(code_in) > DIE_MAX) begin
                            err_d = 1'b1;
                            res_d = '0;
                        end else begin
                            err_d = 1'b0;
                            res_d = OUT_W'(die_i);
                        end
                        state_d = ST_DONE;
                    end else begin
                        lo_d    = '0;
                        hi_d    = IW'(NBP - 1);
                        state_d = ST_PROBE;
                    end
                end
            end
            ST_PROBE: begin
                if (lo_q > hi_q) begin
                    err_d   = 1'b1;
                    res_d   = '0;
                    state_d = ST_DONE;
                end else if (code_q == cur_code) begin
                    err_d   = 1'b0;
                    res_d   = OUT_W'(int'(cur_temp) * MILLI);
                    state_d = ST_DONE;
                end else if (mid > 0 && code_q > cur_code && code_q < prev_code) begin
                    hit_d   = mid[AW-1:0];
                    state_d = ST_PREP;
                end else if (code_q > cur_code) begin
                    hi_d = mid - 1'b1;
                end else begin
                    lo_d = mid + 1'b1;
                end
            end
            ST_PREP: begin
                if (span_i == 0) begin
                    err_d   = 1'b1;
                    res_d   = '0;
                    state_d = ST_DONE;
                end else begin
                    div_load = 1'b1;
                    neg_d    = (numer_l < 0);
                    state_d  = ST_DIVIDE;
                end
            end
            ST_DIVIDE: begin
                if (div_fin) begin
                    err_d   = 1'b0;
                    res_d   = neg_q ? -quo_s : quo_s;
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                state_d = ST_IDLE;
            end
            default: begin
                state_d = ST_IDLE;
            end
        endcase
    end

    // Outputs
    always_comb begin
        busy    = (state_q != ST_IDLE);
        done    = (state_q == ST_DONE);
        err     = err_q;
        temp_mc = res_q;
    end

    // R8: done never lasts two cycles
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: an accepted start raises busy on the next cycle
    a_r8_busy_after_start: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> busy);

    // R9: a start while busy leaves the captured request untouched
    a_r9_hold_code: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && start) |=> ($stable(code_q) && $stable(die_q)));

    // R5: die-sensor requests finish one cycle after acceptance
    a_r5_die_latency: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy && die_mode) |=> done);

    // R6: a valid die-sensor result implies the code lay inside the window
    a_r6_die_window: assert property (@(posedge clk) disable iff (!rst_n)
        (done && die_q && !err) |-> (int'(code_q) >= DIE_MIN && int'(code_q) <= DIE_MAX));

    // R7: an error result reads as zero
    a_r7_err_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (done && err) |-> (temp_mc == '0));

endmodule

// File: tb/sim_thermistor_temp_conv.sv
module sim_thermistor_temp_conv;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [9:0]  code_in = '0;
    logic        die_mode = 1'b0;
    logic        busy;
    logic        done;
    logic        err;
    logic signed [31:0] temp_mc;

    int checks = 0;
    int errors = 0;

    localparam int TAB [34] = '{977, 961, 941, 917, 887, 853, 813, 769, 720, 669,
                                615, 561, 508, 456, 407, 357, 315, 277, 243, 212,
                                186, 162, 140, 107, 94, 82, 72, 64, 56, 50,
                                44, 39, 35, 31};

    always #2 clk = ~clk;

    thermistor_temp_conv u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .code_in  (code_in),
        .die_mode (die_mode),
        .busy     (busy),
        .done     (done),
        .err      (err),
        .temp_mc  (temp_mc)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    // Behavioural reference for one conversion
    function automatic void model(input int c, input bit die, output bit e, output int t);
        int lo;
        int hi;
        int m;
        int nr;
        e = 1'b1;
        t = 0;
        if (die) begin
            if (c >= 488 && c <= 802) begin
                e = 1'b0;
                t = 382100 - 526 * c;
            end
            return;
        end
        lo = 0;
        hi = 33;
        while (lo <= hi) begin
            m = (lo + hi) / 2;
            if (c == TAB[m]) begin
                e = 1'b0;
                t = (-20 + 5 * m) * 1000;
                return;
            end
            if (m > 0 && c > TAB[m] && c < TAB[m-1]) begin
                nr = (c - TAB[m]) * (-20 + 5 * (m - 1)) + (TAB[m-1] - c) * (-20 + 5 * m);
                t = (nr * 1000) / (TAB[m-1] - TAB[m]);
                e = 1'b0;
                return;
            end
            if (c > TAB[m]) hi = m - 1;
            else lo = m + 1;
        end
    endfunction

    task automatic run(input int c, input bit die, input string req, input bit poke);
        bit e;
        int t;
        int waited;
        model(c, die, e, t);
        @(negedge clk);
        code_in  = 10'(c);
        die_mode = die;
        start    = 1'b1;
        @(negedge clk);
        start = 1'b0;
        chk(busy == 1'b1, "R8", "busy after start", longint'(busy), 1);
        if (poke) begin
            start    = 1'b1;
            code_in  = 10'(c) ^ 10'h155;
            die_mode = !die;
        end
        waited = 0;
        while (!done && waited < 400) begin
            @(negedge clk);
            start = 1'b0;
            waited++;
            if (!done) chk(busy == 1'b1, "R8", "busy while pending", longint'(busy), 1);
        end
        start = 1'b0;
        if (!done) begin
            chk(1'b0, req, "no done", 0, 1);
        end else begin
            chk(err == e, req, "err", longint'(err), longint'(e));
            if (e) chk(temp_mc == 0, "R7", "temp on error", longint'(temp_mc), 0);
            else   chk(temp_mc == t, req, "temperature", longint'(temp_mc), longint'(t));
            if (die) chk(waited == 0, "R5", "die latency", longint'(waited), 0);
        end
        for (int k = 0; k < 2; k++) begin
            @(negedge clk);
            chk(done == 1'b0, poke ? "R9" : "R8", "done after pulse", longint'(done), 0);
        end
        chk(busy == 1'b0, "R8", "idle after done", longint'(busy), 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R10: reset state
        chk(busy == 1'b0, "R10", "busy in reset", longint'(busy), 0);
        chk(done == 1'b0, "R10", "done in reset", longint'(done), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(busy == 1'b0, "R10", "busy after reset", longint'(busy), 0);
        chk(done == 1'b0, "R10", "done after reset", longint'(done), 0);
        chk(err == 1'b0, "R10", "err after reset", longint'(err), 0);
        chk(temp_mc == 0, "R10", "temp after reset", longint'(temp_mc), 0);

        run(977, 1'b0, "R3", 1'b0);
        run(31, 1'b0, "R3", 1'b0);
        run(669, 1'b0, "R3", 1'b0);
        run(950, 1'b0, "R4", 1'b0);
        run(40, 1'b0, "R4", 1'b0);
        run(960, 1'b0, "R4", 1'b0);
        run(978, 1'b0, "R2", 1'b0);
        run(30, 1'b0, "R2", 1'b0);
        run(1023, 1'b0, "R2", 1'b0);
        run(0, 1'b0, "R2", 1'b0);
        run(488, 1'b1, "R5", 1'b0);
        run(802, 1'b1, "R5", 1'b0);
        run(600, 1'b1, "R5", 1'b0);
        run(487, 1'b1, "R6", 1'b0);
        run(803, 1'b1, "R6", 1'b0);
        run(0, 1'b1, "R7", 1'b0);
        run(700, 1'b0, "R9", 1'b1);
        run(650, 1'b1, "R9", 1'b1);
        run(5, 1'b0, "R9", 1'b1);
        // R1: every breakpoint maps to its own temperature
        for (int i = 0; i < 34; i++) run(TAB[i], 1'b0, "R1", 1'b0);
        // R2 and R4: every code through the table path
        for (int c = 0; c < 1024; c++) run(c, 1'b0, "R4", 1'b0);
        // R6: stride across and beyond the die window
        for (int c = 0; c < 1024; c += 7) run(c, 1'b1, "R6", 1'b0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL R8 watchdog actual %0d expected %0d", 1, 0);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule